// File: doc/BRIEF.md
# Word-Load Mailbox with Running CRC

This block is a small slave register window that lets a host, talking over a 16-bit management-bus style register interface, push 32-bit words into the memory of an embedded processor. The host writes the target address and the staged data word as two 16-bit halves each. It then writes an execute-and-write command to the control register. The block issues a single write on a simple request/acknowledge memory port, holds a busy flag until the memory acknowledges, and then advances the address by one word. A long image can therefore be streamed with one address setup followed by repeated (stage, execute) pairs.

Every accepted word is folded into a running CRC-16-CCITT, taken over the word's four bytes with the most significant byte first. At the end of a transfer the host reads a single register and compares it with the checksum it computed itself, so the memory never has to be read back. A control bit clears the checksum before a new transfer starts.

Register reads are combinational and have no side effects. Register writes take effect at the next clock edge.

Top module: `memload_mbox`

## Requirements
- R1: After reset every readable register (offsets 0x0200 to 0x0205) reads zero, the busy bit is clear and no memory request is pending.
- R2: Offsets are 0x0202 for the address upper half, 0x0203 for the lower half and 0x0204/0x0205 for the data upper/lower halves, and each reads back what was written. Bits 1:0 of the lower address half always read as zero and drive zero on the memory address. Any offset outside 0x0200 to 0x0205 reads zero.
- R3: A write to control offset 0x0200 with bit 15 (execute) and bit 14 (write) both set, while idle, raises the memory request in the next cycle with the current address and staged data. Busy reads as bit 8 of offset 0x0200 and stays set until the cycle after the acknowledge.
- R4: When the memory acknowledges a pending request, the request drops and the 32-bit address advances by 4 in the same edge. A carry into the upper half is included.
- R5: Offset 0x0201 holds a CRC-16-CCITT (polynomial 0x1021, no reflection, no final inversion). Each accepted write command folds the 32-bit staged word into it, most significant byte first, and the new value is readable the cycle after the command.
- R6: Control bit 12 (CRC reset) clears the CRC to zero in one cycle. When it is set together with an accepted write command, the word is folded onto a zero CRC.
- R7: While busy, an execute command is ignored (no new request, no CRC change). Writes to the address and data registers are also ignored, so the memory port stays stable.
- R8: An execute command without bit 14 set starts no request and leaves the CRC and the address unchanged.
- R9: An acknowledge with no request pending has no effect on the address or the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 16 | Register offset for reads and writes |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Combinational read data for regAddr |
| memReq | output | 1 | Memory write request, held until acknowledged |
| memAddr | output | 32 | Word-aligned memory address |
| memData | output | 32 | Memory write data |
| memAck | input | 1 | Memory write completion |

## Verification
Register readback is combinational, so it is sampled on the falling edge in the same cycle the offset is driven. The effect of a register write appears one edge later and is checked on the falling edge that follows the write cycle. The memory request and the busy bit rise one edge after an accepted command and fall one edge after the acknowledge cycle. The address increment is checked on that same falling edge. The CRC is compared one cycle after each command against a byte-wise model kept in the bench, and random acknowledge delays stretch the busy window so that ignored commands land inside it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_W  = 16;
  localparam int WORD_W = 32;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  localparam logic [REG_W-1:0] OFF_CTRL   = 16'h0200;
  localparam logic [REG_W-1:0] OFF_CRC    = 16'h0201;
  localparam logic [REG_W-1:0] OFF_ADR_HI = 16'h0202;
  localparam logic [REG_W-1:0] OFF_ADR_LO = 16'h0203;
  localparam logic [REG_W-1:0] OFF_DAT_HI = 16'h0204;
  localparam logic [REG_W-1:0] OFF_DAT_LO = 16'h0205;

  localparam int BIT_EXEC  = 15;
  localparam int BIT_WRITE = 14;
  localparam int BIT_CLR   = 12;
  localparam int BIT_BUSY  = 8;

  typedef struct packed {
    logic wrAdrHi;
    logic wrAdrLo;
    logic wrDatHi;
    logic wrDatLo;
    logic crcClear;
    logic issue;
    logic complete;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             memAck,
  output mboxStrobe_t      strb,
  output logic             busy
);
  logic ctrlHit;
  logic reqQ;

  assign ctrlHit = regWr && (regAddr == OFF_CTRL);

  always_comb begin
    strb          = '0;
    strb.wrAdrHi  = regWr && !reqQ && (regAddr == OFF_ADR_HI);
    strb.wrAdrLo  = regWr && !reqQ && (regAddr == OFF_ADR_LO);
    strb.wrDatHi  = regWr && !reqQ && (regAddr == OFF_DAT_HI);
    strb.wrDatLo  = regWr && !reqQ && (regAddr == OFF_DAT_LO);
    strb.crcClear = ctrlHit && regWdata[BIT_CLR];
    strb.issue    = ctrlHit && !reqQ && regWdata[BIT_EXEC] && regWdata[BIT_WRITE];
    strb.complete = reqQ && memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              reqQ <= 1'b0;
    else if (strb.issue)    reqQ <= 1'b1;
    else if (strb.complete) reqQ <= 1'b0;
  end

  assign busy = reqQ;

  // R3: a pending request is held until acknowledged
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memAck) |=> busy);
  // R9: no request appears without an accepted command
  a_r9_no_spurious_req: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(ctrlHit && regWdata[BIT_EXEC] && regWdata[BIT_WRITE])) |=> !busy);
  // R4: acknowledge of a pending request ends it
  a_r4_ack_ends_req: assert property (@(posedge clk) disable iff (!rstN)
    (busy && memAck) |=> !busy);
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int ADDR_STEP = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strb,
  input  logic              busy,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData
);
  localparam int HALF = WORD_W / 2;
  localparam int ALIGN = $clog2(ADDR_STEP);

  logic [WORD_W-1:0] adrQ;
  logic [WORD_W-1:0] datQ;
  logic [CRC_W-1:0]  crcQ;
  logic [CRC_W-1:0]  crcBase;
  logic [CRC_W-1:0]  crcFold;

  // Bit-serial fold of the whole word, most significant bit first.
  always_comb begin
    logic fb;
    crcBase = strb.crcClear ? '0 : crcQ;
    crcFold = crcBase;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb      = crcFold[CRC_W-1] ^ datQ[i];
      crcFold = {crcFold[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adrQ <= '0;
      datQ <= '0;
      crcQ <= '0;
    end else begin
      if (strb.wrAdrHi)  adrQ[WORD_W-1:HALF] <= regWdata;
      if (strb.wrAdrLo)  adrQ[HALF-1:0] <= {regWdata[HALF-1:ALIGN], {ALIGN{1'b0}}};
      if (strb.complete) adrQ <= adrQ + WORD_W'(ADDR_STEP);
      if (strb.wrDatHi)  datQ[WORD_W-1:HALF] <= regWdata;
      if (strb.wrDatLo)  datQ[HALF-1:0] <= regWdata;
      if (strb.issue)         crcQ <= crcFold;
      else if (strb.crcClear) crcQ <= '0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_CTRL:   regRdata[BIT_BUSY] = busy;
      OFF_CRC:    regRdata = crcQ;
      OFF_ADR_HI: regRdata = adrQ[WORD_W-1:HALF];
      OFF_ADR_LO: regRdata = adrQ[HALF-1:0];
      OFF_DAT_HI: regRdata = datQ[WORD_W-1:HALF];
      OFF_DAT_LO: regRdata = datQ[HALF-1:0];
      default:    regRdata = '0;
    endcase
  end

  assign memAddr = adrQ;
  assign memData = datQ;

  // R2: memory address is always word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[ALIGN-1:0] == '0);
  // R4: completion advances the address by one word
  a_r4_advance: assert property (@(posedge clk) disable iff (!rstN)
    strb.complete |=> memAddr == $past(memAddr) + WORD_W'(ADDR_STEP));
  // R7: port contents stay put while a request is outstanding
  a_r7_port_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.complete) |=> ($stable(memAddr) && $stable(memData)));
  // R6: a lone CRC reset leaves zero behind
  a_r6_crc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.crcClear && !strb.issue) |=> crcQ == '0);
endmodule

// File: rtl/memload_mbox.sv
module memload_mbox
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              memReq,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  input  logic              memAck
);
  mboxStrobe_t strb;
  logic        busy;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .memAck(memAck), .strb(strb), .busy(busy)
  );

  mbox_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memAddr(memAddr), .memData(memData)
  );

  assign memReq = busy;
endmodule

// File: tb/memload_mbox_test.sv
module memload_mbox_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        memReq;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memAck = 1'b0;

  int total = 0;
  int bad = 0;
  logic [31:0] expAddr;
  logic [15:0] expCrc;

  always #4 clk = ~clk;

  memload_mbox uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memAck(memAck)
  );

  function automatic logic [15:0] crcWord(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int b = 3; b >= 0; b--) begin
      r = r ^ {w[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] off, input logic [15:0] val);
    @(negedge clk);
    regWr = 1'b1; regAddr = off; regWdata = val;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input logic [15:0] off, input logic [15:0] exp, input string tag);
    regAddr = off;
    #1;
    check(regRdata == exp, tag, {16'h0, regRdata}, {16'h0, exp});
  endtask

  task automatic ackAfter(input int dly);
    repeat (dly) @(negedge clk);
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    check(memReq == 1'b0, "R4 req drops", {31'h0, memReq}, 32'h0);
    expAddr = expAddr + 32'd4;
    check(memAddr == expAddr, "R4 address advance", memAddr, expAddr);
  endtask

  task automatic commit(input logic [31:0] w, input bit tryBusy, input int dly);
    wr(16'h0204, w[31:16]);
    wr(16'h0205, w[15:0]);
    wr(16'h0200, 16'hC000);
    expCrc = crcWord(expCrc, w);
    check(memReq == 1'b1, "R3 request raised", {31'h0, memReq}, 32'h1);
    check(memAddr == expAddr, "R3 request address", memAddr, expAddr);
    check(memData == w, "R3 request data", memData, w);
    rdChk(16'h0200, 16'h0100, "R3 busy bit");
    rdChk(16'h0201, expCrc, "R5 crc after command");
    if (tryBusy) begin
      wr(16'h0204, 16'hDEAD);
      wr(16'h0203, 16'h0040);
      wr(16'h0200, 16'hC000);
      check(memData == w, "R7 data held while busy", memData, w);
      check(memAddr == expAddr, "R7 address held while busy", memAddr, expAddr);
      rdChk(16'h0201, expCrc, "R7 crc unchanged by busy execute");
    end
    ackAfter(dly);
    rdChk(16'h0200, 16'h0000, "R3 busy cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expAddr = '0;
    expCrc = '0;
    // R1 reset state
    for (int o = 16'h0200; o <= 16'h0205; o++) rdChk(16'(o), 16'h0000, "R1 reset read");
    check(memReq == 1'b0, "R1 no request", {31'h0, memReq}, 32'h0);

    // R2 map, alignment and unmapped reads
    wr(16'h0202, 16'h1234);
    wr(16'h0203, 16'hFFFF);
    wr(16'h0204, 16'hA5A5);
    wr(16'h0205, 16'h5A5A);
    rdChk(16'h0202, 16'h1234, "R2 addr hi");
    rdChk(16'h0203, 16'hFFFC, "R2 addr lo aligned");
    rdChk(16'h0204, 16'hA5A5, "R2 data hi");
    rdChk(16'h0205, 16'h5A5A, "R2 data lo");
    rdChk(16'h0206, 16'h0000, "R2 unmapped above");
    rdChk(16'h01FF, 16'h0000, "R2 unmapped below");
    check(memAddr == 32'h1234FFFC, "R2 port aligned", memAddr, 32'h1234FFFC);

    // R4 carry across the halves
    wr(16'h0202, 16'h0000);
    wr(16'h0203, 16'hFFF8);
    expAddr = 32'h0000FFF8;
    commit(32'h01020304, 1'b0, 0);
    commit(32'hFFFFFFFF, 1'b1, 2);
    rdChk(16'h0202, 16'h0001, "R4 carry hi");
    rdChk(16'h0203, 16'h0000, "R4 carry lo");

    // R6 lone CRC reset
    wr(16'h0200, 16'h1000);
    expCrc = '0;
    rdChk(16'h0201, 16'h0000, "R6 crc cleared");

    // R5/R7 random stream with a fixed seed
    void'($urandom(32'h5EED));
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w = $urandom();
      commit(w, ($urandom() % 3) == 0, $urandom() % 5);
    end
    rdChk(16'h0201, expCrc, "R5 crc after stream");

    // R8 execute without write
    wr(16'h0200, 16'h8000);
    check(memReq == 1'b0, "R8 no request", {31'h0, memReq}, 32'h0);
    rdChk(16'h0201, expCrc, "R8 crc unchanged");
    check(memAddr == expAddr, "R8 address unchanged", memAddr, expAddr);

    // R9 stray acknowledge
    @(negedge clk); memAck = 1'b1;
    @(negedge clk); memAck = 1'b0;
    check(memAddr == expAddr, "R9 address unchanged", memAddr, expAddr);
    check(memReq == 1'b0, "R9 no request", {31'h0, memReq}, 32'h0);

    // R6 reset combined with a write command: fold onto zero
    wr(16'h0204, 16'h1234);
    wr(16'h0205, 16'h5678);
    wr(16'h0200, 16'hD000);
    expCrc = crcWord(16'h0000, 32'h12345678);
    rdChk(16'h0201, expCrc, "R6 fold onto zero");
    ackAfter(1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule